// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block watches a set of already-synchronized GPIO input levels and turns each one into a sticky interrupt status bit. A pin's trigger is chosen by two configuration bits, a select bit and an invert bit. With select at 0 the pin is edge sensitive: invert 0 catches rising edges and invert 1 catches falling edges. With select at 1 the pin is level sensitive: invert 0 fires on a low level and invert 1 fires on a high level. The pin configuration comes from a neighbouring register block and reaches this block as plain per-pin inputs.

Status and enable bits are packed into 32-bit words. Pin p lives in bit p%32 of word p/32. A small register port reads and writes these words. The status words are write-one-to-clear. The enable words are plain read/write. A status bit is set by its pin whether or not the pin is enabled. Enable only decides whether a set status bit reaches the single registered host interrupt, which is the OR over all pins of status AND enable.

The register port takes one access per cycle with no back-pressure: a request is made by holding `reg_en` high for one cycle, and it is always accepted in that cycle. A read answers one cycle later with `rd_valid` high for exactly one cycle and the data on `rd_data`. The host must take the answer in that cycle, because there is no ready input. `rd_data` is zero whenever `rd_valid` is low.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset all status bits, all enable bits, `host_irq`, `rd_valid` and `rd_data` are 0.
- R2: With select 0 and invert 0, a 0-to-1 change of a pin's level between two consecutive clock edges sets its status bit at the second edge.
- R3: With select 0 and invert 1, a 1-to-0 change of a pin's level between two consecutive clock edges sets its status bit at the second edge.
- R4: With select 1, the status bit is set at every edge where the level equals the invert bit (invert 0 means low-active, invert 1 means high-active). A clear therefore only takes effect once the level is inactive.
- R5: A write to status word w (byte address 0x80 + 4*w) clears each status bit whose write-data bit is 1 and leaves every bit written with 0 unchanged.
- R6: When a clear and a new detection for the same pin fall on the same clock edge, the status bit ends up set.
- R7: Enable word w is at byte address 0x90 + 4*w and holds the written value. Pin p uses bit p%32 of word p/32 in both banks. Status bits are set whether or not the pin is enabled.
- R8: `host_irq` is a register that, one edge after any pin has both its status bit and its enable bit at 1, is 1, and is 0 one edge after no pin does.
- R9: A change of select or invert with a steady level creates no edge detection. The first edge after reset creates no edge detection whatever the level.
- R10: A read request (`reg_en`=1, `reg_we`=0) gives `rd_valid`=1 on the next cycle with the word as it stood in the request cycle. Addresses outside both banks read 0. Writes give no `rd_valid`.
- R11: Bits for pin numbers at or above NUM_PINS read 0 in both banks, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| trig_sel | input | NUM_PINS | Per pin: 0 edge, 1 level trigger |
| trig_inv | input | NUM_PINS | Per pin: invert (falling edge / high level when 1) |
| reg_en | input | 1 | Register access request, accepted every cycle |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | ADDR_W | Byte address of the word |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read answer present (one cycle after request) |
| rd_data | output | 32 | Read answer, zero when `rd_valid` is 0 |
| host_irq | output | 1 | Registered combined interrupt, active high |

## Verification
The functions that can fall in the same cycle are the write-one-to-clear of a status bit and a fresh detection on that same pin, whether from an edge or from a persisting level. The bench provokes the edge case directly: it raises a rising-edge pin in the same cycle as it writes a 1 to that pin's status bit. It provokes the level case by clearing a level-high pin while the level stays active. In both cases a later read-back must show the bit still set. Random traffic then mixes clears with pin toggles on every cycle, and a cycle-accurate bench model judges every read answer and every `host_irq` value.

// File: rtl/gid_pkg.sv
package gid_pkg;

  localparam int unsigned REG_W = 32;

  // {select, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  // Detection for one pin; edges need a valid previous sample (primed)
  function automatic logic trig_hit(input logic sel, input logic inv,
                                    input logic lvl, input logic prev,
                                    input logic primed);
    logic r;
    case (trig_e'({sel, inv}))
      TRIG_RISE: r = primed & lvl & ~prev;
      TRIG_FALL: r = primed & ~lvl & prev;
      TRIG_LOW:  r = ~lvl;
      default:   r = lvl;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gid_pin_cell.sv
module gid_pin_cell
  import gid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic primed,
  input  logic lvl,
  input  logic sel,
  input  logic inv,
  input  logic clr,
  output logic st_q
);

  logic prev_q;
  logic hit;

  always_comb hit = trig_hit(sel, inv, lvl, prev_q, primed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= lvl;
      st_q   <= (st_q & ~clr) | hit;
    end
  end

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !sel && !inv && lvl && !$past(lvl)) |=> st_q);

  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !sel && inv && !lvl && $past(lvl)) |=> st_q);

  p_level_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (lvl == inv)) |=> st_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !st_q);

  p_clear_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> st_q);

  p_set_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q) |-> $past(hit));

endmodule

// File: rtl/gid_bank.sv
module gid_bank
  import gid_pkg::*;
#(
  parameter int unsigned NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             primed,
  input  logic [NBITS-1:0] lvl,
  input  logic [NBITS-1:0] sel,
  input  logic [NBITS-1:0] inv,
  input  logic             stat_wr,
  input  logic             en_wr,
  input  logic [NBITS-1:0] wdata,
  output logic [NBITS-1:0] stat_bits,
  output logic [NBITS-1:0] en_bits,
  output logic             pend
);

  logic [NBITS-1:0] clr_vec;

  assign clr_vec = {NBITS{stat_wr}} & wdata;

  for (genvar b = 0; b < NBITS; b++) begin : g_pin
    gid_pin_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .primed (primed),
      .lvl    (lvl[b]),
      .sel    (sel[b]),
      .inv    (inv[b]),
      .clr    (clr_vec[b]),
      .st_q   (stat_bits[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bits <= '0;
    end else if (en_wr) begin
      en_bits <= wdata;
    end
  end

  assign pend = |(stat_bits & en_bits);

  p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_bits));

endmodule

// File: rtl/gid_regport.sv
module gid_regport
  import gid_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STAT_BASE = 32'h80,
  parameter int unsigned EN_BASE   = 32'h90,
  localparam int unsigned FLAT_W   = NUM_WORDS * REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [FLAT_W-1:0]    stat_flat,
  input  logic [FLAT_W-1:0]    en_flat,
  output logic [NUM_WORDS-1:0] stat_wr,
  output logic [NUM_WORDS-1:0] en_wr,
  output logic                 rd_valid,
  output logic [REG_W-1:0]     rd_data
);

  logic             rd_req;
  logic [REG_W-1:0] rd_mux;

  assign rd_req = reg_en & ~reg_we;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(STAT_BASE + 4 * w);
    localparam logic [ADDR_W-1:0] E_ADDR = ADDR_W'(EN_BASE + 4 * w);
    assign stat_wr[w] = reg_en & reg_we & (reg_addr == S_ADDR);
    assign en_wr[w]   = reg_en & reg_we & (reg_addr == E_ADDR);
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr == ADDR_W'(STAT_BASE + 4 * w)) rd_mux = stat_flat[w*REG_W +: REG_W];
      if (reg_addr == ADDR_W'(EN_BASE + 4 * w))   rd_mux = en_flat[w*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? rd_mux : '0;
    end
  end

  p_rd_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_wr_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we) |=> !rd_valid);

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gid_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 95,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STAT_BASE = 32'h80,
  parameter int unsigned EN_BASE   = 32'h90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] trig_sel,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic                rd_valid,
  output logic [REG_W-1:0]    rd_data,
  output logic                host_irq
);

  localparam int unsigned NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int unsigned FLAT_W    = NUM_WORDS * REG_W;

  logic                 primed_q;
  logic [FLAT_W-1:0]    stat_flat;
  logic [FLAT_W-1:0]    en_flat;
  logic [NUM_WORDS-1:0] stat_wr;
  logic [NUM_WORDS-1:0] en_wr;
  logic [NUM_WORDS-1:0] pend_w;

  // Edge history becomes valid one edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int unsigned LO = w * REG_W;
    localparam int unsigned NB = (NUM_PINS - LO >= REG_W) ? REG_W : (NUM_PINS - LO);

    gid_bank #(.NBITS(NB)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .primed    (primed_q),
      .lvl       (pin_level[LO +: NB]),
      .sel       (trig_sel[LO +: NB]),
      .inv       (trig_inv[LO +: NB]),
      .stat_wr   (stat_wr[w]),
      .en_wr     (en_wr[w]),
      .wdata     (reg_wdata[NB-1:0]),
      .stat_bits (stat_flat[LO +: NB]),
      .en_bits   (en_flat[LO +: NB]),
      .pend      (pend_w[w])
    );

    if (NB < REG_W) begin : g_pad
      assign stat_flat[LO+NB +: REG_W-NB] = '0;
      assign en_flat[LO+NB +: REG_W-NB]   = '0;
    end
  end

  gid_regport #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE),
    .EN_BASE   (EN_BASE)
  ) u_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .stat_flat (stat_flat),
    .en_flat   (en_flat),
    .stat_wr   (stat_wr),
    .en_wr     (en_wr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= |pend_w;
  end

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_w) |=> host_irq);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_w) |=> !host_irq);

  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stat_wr, en_wr}) <= 1);

endmodule

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_level = '0;
  logic [NP-1:0] trig_sel = '0;
  logic [NP-1:0] trig_inv = '0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic rd_valid, host_irq;
  logic [31:0] rd_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_agg u_gpio_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .trig_sel(trig_sel),
    .trig_inv(trig_inv), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .host_irq(host_irq)
  );

  // ---------------- reference model built from the requirements ----------
  logic [NP-1:0] m_st, m_en, m_prev;
  logic m_primed, m_irq, m_rv;
  logic [31:0] m_rd;

  function automatic logic exp_hit(logic s, logic i, logic l, logic p, logic pr);
    if (!s) return pr && (i ? (!l && p) : (l && !p)); // R2 / R3 / R9
    return l == i;                                     // R4
  endfunction

  function automatic logic [31:0] m_word(logic [7:0] a);
    logic [31:0] r = '0;
    for (int w = 0; w < 3; w++) begin
      for (int b = 0; b < 32; b++) begin
        if (w*32+b < NP) begin
          if (a == 8'h80 + 8'(4*w)) r[b] = m_st[w*32+b];
          if (a == 8'h90 + 8'(4*w)) r[b] = m_en[w*32+b];
        end
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_prev <= '0; m_primed <= 0;
      m_irq <= 0; m_rv <= 0; m_rd <= '0;
    end else begin
      logic [NP-1:0] nst, nen;
      nst = m_st; nen = m_en;
      for (int p = 0; p < NP; p++) begin
        logic clr;
        clr = reg_en && reg_we && reg_addr == 8'h80 + 8'(4*(p/32)) && reg_wdata[p%32];
        if (clr) nst[p] = 1'b0;
        if (exp_hit(trig_sel[p], trig_inv[p], pin_level[p], m_prev[p], m_primed)) nst[p] = 1'b1;
        if (reg_en && reg_we && reg_addr == 8'h90 + 8'(4*(p/32))) nen[p] = reg_wdata[p%32];
      end
      m_irq <= |(m_st & m_en);
      m_rv <= reg_en && !reg_we;
      m_rd <= (reg_en && !reg_we) ? m_word(reg_addr) : 32'h0;
      m_st <= nst; m_en <= nen; m_prev <= pin_level; m_primed <= 1'b1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R8 host_irq vs model", {31'b0, host_irq}, {31'b0, m_irq});
      check("R10 rd_valid vs model", {31'b0, rd_valid}, {31'b0, m_rv});
      check("R10 rd_data vs model", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_en = 1; reg_we = 0; reg_addr = a;
    tick();
    reg_en = 0;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    pin_level[10] = 1'b1; // held high through reset
    repeat (3) tick();
    check("R1 host_irq at reset", {31'b0, host_irq}, 32'h0);
    check("R1 rd_valid at reset", {31'b0, rd_valid}, 32'h0);
    rst_n = 1;
    cmp_on = 1;
    tick();
    rd(8'h80, v); check("R9 no edge on first cycle after reset", v, 32'h0);
    rd(8'h90, v); check("R1 enable word0 reset", v, 32'h0);
    rd(8'h84, v); check("R1 status word1 reset", v, 32'h0);

    // R2 rising edge, status without enable (R7), then irq timing (R8)
    pin_level[5] = 1; tick();
    rd(8'h80, v); check("R2 rising edge pin5", v, 32'h20);
    check("R7 status set while disabled, irq low", {31'b0, host_irq}, 32'h0);
    wr(8'h90, 32'h20);
    check("R8 irq not yet after enable write", {31'b0, host_irq}, 32'h0);
    tick();
    check("R8 irq one edge after pending", {31'b0, host_irq}, 32'h1);

    // R5 write-one-to-clear
    wr(8'h80, 32'h0);
    rd(8'h80, v); check("R5 write of zero keeps status", v, 32'h20);
    wr(8'h80, 32'h20);
    rd(8'h80, v); check("R5 write of one clears", v, 32'h0);
    check("R8 irq drops after clear", {31'b0, host_irq}, 32'h0);
    wr(8'h90, 32'h0);

    // R3 falling edge on pin 40 (word1 bit8), R7 enable word1
    trig_inv[40] = 1; tick();
    pin_level[40] = 1; tick();
    rd(8'h84, v); check("R3 rising ignored in falling mode", v, 32'h0);
    pin_level[40] = 0; tick();
    rd(8'h84, v); check("R3 falling edge pin40", v, 32'h100);
    wr(8'h94, 32'h100); tick();
    check("R7 pin40 enable in word1 bit8 drives irq", {31'b0, host_irq}, 32'h1);
    wr(8'h94, 32'h0); wr(8'h84, 32'h100); trig_inv[40] = 0;

    // R9 config change with steady level
    trig_inv[70] = 1; pin_level[70] = 1; tick();
    rd(8'h88, v); check("R9 rise ignored in fall mode pin70", v, 32'h0);
    trig_inv[70] = 0; tick(); tick();
    rd(8'h88, v); check("R9 config change alone no edge", v, 32'h0);
    pin_level[70] = 0; tick();

    // R4 level high on pin 94 (word2 bit30)
    trig_sel[94] = 1; trig_inv[94] = 1; pin_level[94] = 1; tick();
    rd(8'h88, v); check("R4 high level pin94", v, 32'h4000_0000);
    wr(8'h88, 32'h4000_0000);
    rd(8'h88, v); check("R4 clear while level active re-sets", v, 32'h4000_0000);
    pin_level[94] = 0; tick();
    wr(8'h88, 32'h4000_0000);
    rd(8'h88, v); check("R4 clear after level inactive", v, 32'h0);
    trig_sel[94] = 0; trig_inv[94] = 0;
    // R4 low level pin 33
    trig_sel[33] = 1; tick();
    rd(8'h84, v); check("R4 low level pin33", v, 32'h2);
    trig_sel[33] = 0; tick();
    wr(8'h84, 32'h2);
    rd(8'h84, v); check("R4 pin33 cleared after mode change", v, 32'h0);

    // R6 edge and clear on the same edge
    pin_level[2] = 1; tick();
    pin_level[2] = 0; tick();
    rd(8'h80, v); check("R6 setup pin2 set", v, 32'h4);
    pin_level[2] = 1;
    wr(8'h80, 32'h4);
    rd(8'h80, v); check("R6 edge wins over same-cycle clear", v, 32'h4);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R5 all-ones clears word", v, 32'h0);

    // R11 / R10 unmapped bits and addresses
    wr(8'h98, 32'hFFFF_FFFF);
    check("R10 no rd_valid after write", {31'b0, rd_valid}, 32'h0);
    rd(8'h98, v); check("R11 enable bits above last pin read 0", v, 32'h7FFF_FFFF);
    wr(8'h98, 32'h0);
    rd(8'h9C, v); check("R10 address past enable bank reads 0", v, 32'h0);
    rd(8'h8C, v); check("R10 address past status bank reads 0", v, 32'h0);
    rd(8'h00, v); check("R10 unrelated address reads 0", v, 32'h0);

    // constrained random traffic, judged by the model comparator
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 7) == 0) pin_level[p] = ~pin_level[p];
      if ($urandom_range(0, 15) == 0) begin
        int p = $urandom_range(0, NP-1);
        trig_sel[p] = ($urandom_range(0, 3) == 0);
        trig_inv[p] = $urandom_range(0, 1) != 0;
      end
      case ($urandom_range(0, 9))
        0, 1, 2: begin
          reg_en = 1; reg_we = 0;
          reg_addr = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255))
                     : 8'h80 + 8'(4 * $urandom_range(0, 7));
        end
        3, 4: begin
          reg_en = 1; reg_we = 1; reg_addr = 8'h80 + 8'(4 * $urandom_range(0, 2));
          reg_wdata = $urandom();
        end
        5: begin
          reg_en = 1; reg_we = 1; reg_addr = 8'h90 + 8'(4 * $urandom_range(0, 2));
          reg_wdata = $urandom() & $urandom();
        end
        default: reg_en = 0;
      endcase
      tick();
      reg_en = 0;
    end
    tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule